// File: doc/BRIEF.md
# Quiet-Noisy Delay Test Sequencer

This controller steps a low-power two-bits-per-cycle scan chain of `CELLS` cells through one skew-load two-pattern delay test. A single start request launches a fixed run: one cycle that clears the cells, a quiet load at half clock rate with the cell data outputs held at zero, one full-rate noisy shift, one functional capture cycle, and a quiet unload of the captured responses. The chain, the clock divider and the tester link are outside the block. It only drives the control levels they obey.

The quiet load lasts `CELLS/2` cycles because the chain moves two bits per cycle. Releasing the cell reset for the single noisy shift makes the first pattern visible on the data outputs. The noisy shift then places the second pattern there on the very next cycle, so launch and second pattern are one cycle apart. The chain length is the parameter `CELLS` and must be even. All outputs are plain control levels. There is no streaming data path, so no valid/ready handshake applies.

Top module: `qn_delay_seq`

## Requirements
- R1: While rst_n is low and after its release with no start, the block is idle: phase code 0 and busy, done, scan_en, cell_rst, half_rate and capture all low. Pulling rst_n low mid-run returns it to idle.
- R2: A start sampled high in idle is followed by exactly one clear cycle: phase code 1, cell_rst high, scan_en low, half_rate low, busy high.
- R3: The quiet load follows the clear cycle and lasts exactly CELLS/2 cycles, with phase code 2 and scan_en, cell_rst and half_rate all high.
- R4: Exactly one noisy shift cycle follows the load: phase code 3, scan_en high, cell_rst low, half_rate low.
- R5: Exactly one capture cycle follows the noisy shift: phase code 4, scan_en low, cell_rst low, capture high. capture is high in no other cycle.
- R6: The quiet unload follows the capture and lasts exactly CELLS/2 cycles, with phase code 5 and scan_en, cell_rst and half_rate all high.
- R7: After the unload, done is high for exactly one cycle (phase code 6, busy and all chain controls low), and the block is idle on the next cycle.
- R8: busy is high from the clear cycle through the last unload cycle, which is CELLS+3 cycles, and low otherwise.
- R9: A start sampled high in any non-idle cycle, including the done cycle, has no effect: the run keeps its timing and the block idles afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one delay test run, sampled in idle |
| busy | output | 1 | Run in progress (clear through unload) |
| done | output | 1 | One-cycle pulse after the unload |
| scan_en | output | 1 | Chain shift enable |
| cell_rst | output | 1 | Cell reset / quiet mode: data outputs forced to zero |
| half_rate | output | 1 | Select halved shift clock for quiet phases |
| capture | output | 1 | Functional capture strobe |
| phase | output | 3 | Current phase code (0 idle .. 6 done) |

## Verification
Every output is decoded from the phase register, so a start sampled at a rising edge appears as the clear phase right after that edge. Run cycle k (clear = 0) is then fixed: quiet load at k = 1..CELLS/2, noisy shift at CELLS/2+1, capture at CELLS/2+2, unload through CELLS+2, done at CELLS+3, and idle at CELLS+4. The bench drives start and samples all outputs on falling edges, and compares the full output vector against this arithmetic schedule in every cycle of the run. It repeats the run with a stray start injected at every busy and done cycle in turn.

// File: rtl/qn_seq_pkg.sv
package qn_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLEAR  = 3'd1,
    PH_QLOAD  = 3'd2,
    PH_NOISY  = 3'd3,
    PH_CAPT   = 3'd4,
    PH_UNLOAD = 3'd5,
    PH_DONE   = 3'd6
  } phase_e;
endpackage

// File: rtl/qn_phase_timer.sv
module qn_phase_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic expire
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] START_VAL = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= START_VAL;
    else if (en && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expire = en && (cnt == '0);

  // R3
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == START_VAL));
endmodule

// File: rtl/qn_ctrl_decode.sv
module qn_ctrl_decode
  import qn_seq_pkg::*;
(
  input  phase_e ph,
  output logic   busy,
  output logic   done,
  output logic   scan_en,
  output logic   cell_rst,
  output logic   half_rate,
  output logic   capture
);
  always_comb begin
    busy      = 1'b0;
    done      = 1'b0;
    scan_en   = 1'b0;
    cell_rst  = 1'b0;
    half_rate = 1'b0;
    capture   = 1'b0;
    unique case (ph)
      PH_CLEAR: begin busy = 1'b1; cell_rst = 1'b1; end
      PH_QLOAD, PH_UNLOAD: begin
        busy = 1'b1; scan_en = 1'b1; cell_rst = 1'b1; half_rate = 1'b1;
      end
      PH_NOISY: begin busy = 1'b1; scan_en = 1'b1; end
      PH_CAPT:  begin busy = 1'b1; capture = 1'b1; end
      PH_DONE:  done = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/qn_delay_seq.sv
module qn_delay_seq
  import qn_seq_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       scan_en,
  output logic       cell_rst,
  output logic       half_rate,
  output logic       capture,
  output logic [2:0] phase
);
  localparam int HALF = CELLS / 2;
  localparam int LW   = $clog2(HALF + 2);

  initial assert (CELLS >= 2 && CELLS % 2 == 0);

  phase_e state, state_nx;
  logic   t_load, t_en, t_expire;

  assign t_load = (state == PH_CLEAR) || (state == PH_CAPT);
  assign t_en   = (state == PH_QLOAD) || (state == PH_UNLOAD);

  qn_phase_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .en(t_en), .expire(t_expire)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:   if (start) state_nx = PH_CLEAR;
      PH_CLEAR:  state_nx = PH_QLOAD;
      PH_QLOAD:  if (t_expire) state_nx = PH_NOISY;
      PH_NOISY:  state_nx = PH_CAPT;
      PH_CAPT:   state_nx = PH_UNLOAD;
      PH_UNLOAD: if (t_expire) state_nx = PH_DONE;
      PH_DONE:   state_nx = PH_IDLE;
      default:   state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= state_nx;
  end

  qn_ctrl_decode u_dec (
    .ph(state), .busy(busy), .done(done), .scan_en(scan_en),
    .cell_rst(cell_rst), .half_rate(half_rate), .capture(capture)
  );

  assign phase = state;

  // independent length counter for quiet phases
  logic [LW-1:0] qlen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     qlen <= '0;
    else if (t_en)  qlen <= qlen + 1'b1;
    else            qlen <= '0;
  end

  // R3
  qload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_QLOAD && state_nx == PH_NOISY) |-> (qlen == LW'(HALF - 1)));
  // R6
  unload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_UNLOAD && state_nx == PH_DONE) |-> (qlen == LW'(HALF - 1)));
  // R2
  clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |=> (phase == 3'd2 && scan_en && cell_rst));
  // R4
  noisy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |=> (capture && !scan_en && !cell_rst));
  // R5
  capture_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!scan_en && $past(phase) == 3'd3));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && phase == 3'd0));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase != 3'd0 && phase != 3'd6) |=> (busy || done));
endmodule

// File: tb/qn_delay_seq_test.sv
`timescale 1ns/1ps
module qn_delay_seq_test;
  localparam int CELLS = 6;
  localparam int H     = CELLS / 2;
  localparam int LAST  = 2 * H + 4;   // idle index after run

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, scan_en, cell_rst, half_rate, capture;
  logic [2:0] phase;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  qn_delay_seq #(.CELLS(CELLS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .scan_en(scan_en), .cell_rst(cell_rst), .half_rate(half_rate),
    .capture(capture), .phase(phase)
  );

  // {busy,done,scan_en,cell_rst,half_rate,capture,phase}
  function automatic logic [8:0] expect_at(int k);
    if (k == 0)               return {6'b100100, 3'd1};
    if (k <= H)               return {6'b101110, 3'd2};
    if (k == H + 1)           return {6'b101000, 3'd3};
    if (k == H + 2)           return {6'b100001, 3'd4};
    if (k <= 2 * H + 2)       return {6'b101110, 3'd5};
    if (k == 2 * H + 3)       return {6'b010000, 3'd6};
    return 9'd0;
  endfunction

  function automatic string req_at(int k);
    if (k == 0)               return "R2/R8";
    if (k <= H)               return "R3/R8";
    if (k == H + 1)           return "R4";
    if (k == H + 2)           return "R5";
    if (k <= 2 * H + 2)       return "R6";
    if (k == 2 * H + 3)       return "R7";
    return "R7/R9 idle";
  endfunction

  function automatic logic [8:0] outs();
    return {busy, done, scan_en, cell_rst, half_rate, capture, phase};
  endfunction

  task automatic check(string req, logic [8:0] exp_v);
    n_run++;
    if (outs() !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, outs(), exp_v);
    end
  endtask

  // inject = -1: no stray start; otherwise start held during run cycle inject
  task automatic run_seq(int inject);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k <= LAST; k++) begin
      check(inject < 0 ? req_at(k) : {req_at(k), " R9"}, expect_at(k));
      start = (k == inject);
      @(negedge clk);
      start = 1'b0;
    end
    check("R9 stays idle", 9'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 in reset", 9'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", 9'd0);

    run_seq(-1);                             // R2..R8 nominal
    for (int j = 0; j <= 2 * H + 3; j++)     // R9 sweep over busy and done
      run_seq(j);

    // R1: reset mid-run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (H) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 9'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after mid-run reset", 9'd0);
    run_seq(-1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule